// File: doc/BRIEF.md
# Frame-Length Decoded Serial Write Port

This block is the write side of a byte-oriented, SPI-compatible serial port that carries no address bits. An active-low frame enable brackets each transfer. Bits arrive most-significant first on rising serial-clock edges. When the enable returns high, the number of serial clocks seen in the frame selects the target: a one-byte frame writes a loop's control register, a two-byte frame writes the shared divider staging register, and a three-byte frame writes a loop's main divider register. The first bit of one-byte and three-byte frames steers the write to the main loop (0) or the auxiliary loop (1).

Writing a loop's main divider register also copies the 13 low bits of the staging register into that loop's reference divider, and a one-cycle load strobe marks the copy. A loop's reference and main divide ratios therefore change together. The serial clock, enable and data pins are oversampled by the system clock. A cascade output replays the incoming stream 24 bits late, changing on falling serial-clock edges. This lets several ports share one chain, with the last port keeping the final 24 bits of a long frame.

Top module: `serial_len_port`

## Requirements
- R1: Data is taken on each rising `sclk` edge while `sen_n` is low, and the first bit taken becomes the most significant bit of the frame.
- R2: A frame of exactly 8 clocks writes its low 7 bits to `cfg_main` when its first bit is 0, and to `cfg_aux` when it is 1.
- R3: A frame of exactly 16 clocks drives its first 3 bits onto `rsel` at once and stores its low 13 bits in the staging register. `rdiv_main` and `rdiv_aux` do not change.
- R4: A frame of exactly 24 clocks writes its low 23 bits to `a_main` (first bit 0) or `a_aux` (first bit 1). In the same cycle it copies the staging register into that loop's `rdiv_*` and pulses that loop's `ld_*` high for exactly one system clock.
- R5: A frame of 0 to 7, 9 to 15, 17 to 23 or 25 to 31 clocks changes no output register.
- R6: A frame of 32 or more clocks acts as a 24-clock frame made of its last 24 bits.
- R7: No register output changes while a frame is in progress. The write takes place only when `sen_n` rises.
- R8: `sclk` edges while `sen_n` is high are ignored, and each frame starts with an empty bit count.
- R9: A `sen_n` edge seen while `sclk` is high puts the port out of step: it takes no bits and commits no frame until `sen_n` is high and `sclk` is low together.
- R10: On each falling `sclk` edge in a frame, `sdo` takes the bit received 24 rising edges earlier. While `sen_n` is high, `sdo` is 0.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sen_n | input | 1 | Active-low frame enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Cascade data out |
| cfg_main | output | 7 | Main loop control register |
| cfg_aux | output | 7 | Auxiliary loop control register |
| rsel | output | 3 | Immediate upper field of the staging register |
| a_main | output | 23 | Main loop divider register |
| a_aux | output | 23 | Auxiliary loop divider register |
| rdiv_main | output | 13 | Main loop reference divider (second buffer) |
| rdiv_aux | output | 13 | Auxiliary loop reference divider (second buffer) |
| ld_main | output | 1 | One-cycle strobe when the main loop dividers load |
| ld_aux | output | 1 | One-cycle strobe when the auxiliary loop dividers load |

## Verification
A pin change passes through two synchronizer flops and one edge-history flop, so every register, strobe and `sdo` result appears on the third rising `clk` edge after the pin moves. The bench holds each serial pin level for four system clocks and samples outputs on falling `clk` edges after that hold, so every result has settled by the time it is read. The load strobes are counted over a window of several cycles after the frame closes, which checks both that each pulse occurs and that it lasts exactly one cycle.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
package slp_pkg;
  localparam int C_BITS   = 7;
  localparam int R_BITS   = 13;
  localparam int RHI_BITS = 3;
  localparam int A_BITS   = 23;
  localparam int C_LEN    = C_BITS + 1;
  localparam int R_LEN    = R_BITS + RHI_BITS;
  localparam int A_LEN    = A_BITS + 1;
  localparam int CNT_SAT  = A_LEN + 8;
  localparam int CNT_W    = $clog2(CNT_SAT + 1);
  localparam int LOOPS    = 2;

  typedef enum logic [1:0] {FK_NONE, FK_C, FK_R, FK_A} fkind_e;

  function automatic fkind_e kind_of(logic [CNT_W-1:0] n);
    if (n == CNT_W'(C_LEN))        return FK_C;
    else if (n == CNT_W'(R_LEN))   return FK_R;
    else if (n == CNT_W'(A_LEN))   return FK_A;
    else if (n >= CNT_W'(CNT_SAT)) return FK_A;
    else                           return FK_NONE;
  endfunction
endpackage

// File: rtl/slp_sync.sv
`timescale 1ns/1ps
module slp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{rst_val}};
      prev <= rst_val;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/slp_frame.sv
`timescale 1ns/1ps
module slp_frame
  import slp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             idle_s,
  input  logic             idle_rise,
  input  logic             idle_fall,
  input  logic             sdi_s,
  output logic [A_LEN-1:0] shreg,
  output logic [CNT_W-1:0] count,
  output logic             commit,
  output logic             sdo
);
  logic desync_q;
  logic take;

  assign take   = sclk_rise && !idle_s && !desync_q;
  assign commit = idle_rise && !desync_q && !sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desync_q <= 1'b0;
    end else if ((idle_rise || idle_fall) && sclk_s) begin
      desync_q <= 1'b1;
    end else if (idle_s && !sclk_s) begin
      desync_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      count <= '0;
      sdo   <= 1'b0;
    end else if (idle_s) begin
      shreg <= '0;
      count <= '0;
      sdo   <= 1'b0;
    end else begin
      if (take) begin
        shreg <= {shreg[A_LEN-2:0], sdi_s};
        if (count != CNT_W'(CNT_SAT)) count <= count + 1'b1;
      end
      if (sclk_fall && !desync_q) sdo <= shreg[A_LEN-1];
    end
  end

  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idle_s |=> (count == '0) && (shreg == '0));
  a_r1_lsb_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> shreg[0] == $past(sdi_s));
  a_r9_desync_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (desync_q && !idle_s) |=> $stable(count));
  a_r10_sdo_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    idle_s |=> !sdo);
endmodule

// File: rtl/slp_bank.sv
`timescale 1ns/1ps
module slp_bank
  import slp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [CNT_W-1:0]            count,
  input  logic [A_LEN-1:0]            shreg,
  output logic [LOOPS-1:0][C_BITS-1:0] cfg,
  output logic [LOOPS-1:0][A_BITS-1:0] areg,
  output logic [LOOPS-1:0][R_BITS-1:0] rdiv,
  output logic [LOOPS-1:0]             ld,
  output logic [RHI_BITS-1:0]          rhi
);
  fkind_e           kind;
  logic [R_BITS-1:0] rfirst;

  assign kind = kind_of(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhi    <= '0;
      rfirst <= '0;
    end else if (commit && kind == FK_R) begin
      rhi    <= shreg[R_LEN-1 -: RHI_BITS];
      rfirst <= shreg[R_BITS-1:0];
    end
  end

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    logic c_hit, a_hit;
    assign c_hit = commit && kind == FK_C && shreg[C_LEN-1] == g[0];
    assign a_hit = commit && kind == FK_A && shreg[A_LEN-1] == g[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[g]  <= '0;
        areg[g] <= '0;
        rdiv[g] <= '0;
        ld[g]   <= 1'b0;
      end else begin
        ld[g] <= a_hit;
        if (c_hit) cfg[g] <= shreg[C_BITS-1:0];
        if (a_hit) begin
          areg[g] <= shreg[A_BITS-1:0];
          rdiv[g] <= rfirst;
        end
      end
    end

    a_r4_copy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld[g] |-> rdiv[g] == $past(rfirst));
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ld[g] |=> !ld[g]);
  end

  a_r4_one_loop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld));
endmodule

// File: rtl/serial_len_port.sv
`timescale 1ns/1ps
module serial_len_port
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                sen_n,
  input  logic                sdi,
  output logic                sdo,
  output logic [C_BITS-1:0]   cfg_main,
  output logic [C_BITS-1:0]   cfg_aux,
  output logic [RHI_BITS-1:0] rsel,
  output logic [A_BITS-1:0]   a_main,
  output logic [A_BITS-1:0]   a_aux,
  output logic [R_BITS-1:0]   rdiv_main,
  output logic [R_BITS-1:0]   rdiv_aux,
  output logic                ld_main,
  output logic                ld_aux
);
  localparam int PINS = 3;
  localparam int P_SCLK = 0;
  localparam int P_IDLE = 1;
  localparam int P_SDI  = 2;

  logic [PINS-1:0] pin_q, pin_rise, pin_fall;
  logic [A_LEN-1:0] shreg;
  logic [CNT_W-1:0] count;
  logic             commit;
  logic [LOOPS-1:0][C_BITS-1:0] cfg;
  logic [LOOPS-1:0][A_BITS-1:0] areg;
  logic [LOOPS-1:0][R_BITS-1:0] rdiv;
  logic [LOOPS-1:0]             ld;

  slp_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdi, sen_n, sclk}),
    .rst_val(3'b010),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  slp_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pin_q[P_SCLK]), .sclk_rise(pin_rise[P_SCLK]), .sclk_fall(pin_fall[P_SCLK]),
    .idle_s(pin_q[P_IDLE]), .idle_rise(pin_rise[P_IDLE]), .idle_fall(pin_fall[P_IDLE]),
    .sdi_s(pin_q[P_SDI]),
    .shreg(shreg), .count(count), .commit(commit), .sdo(sdo)
  );

  slp_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .count(count), .shreg(shreg),
    .cfg(cfg), .areg(areg), .rdiv(rdiv), .ld(ld), .rhi(rsel)
  );

  assign cfg_main  = cfg[0];
  assign cfg_aux   = cfg[1];
  assign a_main    = areg[0];
  assign a_aux     = areg[1];
  assign rdiv_main = rdiv[0];
  assign rdiv_aux  = rdiv[1];
  assign ld_main   = ld[0];
  assign ld_aux    = ld[1];

  a_r5_bad_length_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && kind_of(count) == FK_NONE) |=>
      $stable(cfg) && $stable(areg) && $stable(rdiv) && $stable(rsel));
  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg) && $stable(areg) && $stable(rdiv) && $stable(rsel));
  a_r3_rdiv_unmoved: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && kind_of(count) == FK_R) |=> $stable(rdiv) && ld == '0);
endmodule

// File: tb/sim_serial_len_port.sv
`timescale 1ns/1ps
module sim_serial_len_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sen_n = 1'b1, sdi = 1'b0;
  logic sdo, ld_main, ld_aux;
  logic [6:0] cfg_main, cfg_aux;
  logic [2:0] rsel;
  logic [22:0] a_main, a_aux;
  logic [12:0] rdiv_main, rdiv_aux;
  int total = 0, bad = 0;
  int ld_m_cnt = 0, ld_a_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_len_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdi(sdi), .sdo(sdo),
    .cfg_main(cfg_main), .cfg_aux(cfg_aux), .rsel(rsel), .a_main(a_main), .a_aux(a_aux),
    .rdiv_main(rdiv_main), .rdiv_aux(rdiv_aux), .ld_main(ld_main), .ld_aux(ld_aux)
  );

  always @(posedge clk) begin
    if (ld_main) ld_m_cnt <= ld_m_cnt + 1;
    if (ld_aux)  ld_a_cnt <= ld_a_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sdi = b; sclk = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  task automatic frame(input logic [63:0] data, input int n);
    sen_n = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) bit_out(data[i]);
    sen_n = 1'b1; tick(6);
  endtask

  task automatic t_reset;
    check("R11 cfg", {18'd0, cfg_main, cfg_aux}, 0);
    check("R11 a", {9'd0, a_main} | {9'd0, a_aux}, 0);
    check("R11 rdiv/rsel/sdo", {rdiv_main, rdiv_aux, rsel, sdo, ld_main, ld_aux}, 0);
  endtask

  task automatic t_cfg;
    frame(64'h35, 8);
    check("R2 main cfg", cfg_main, 32'h35);
    frame(64'hAA, 8);
    check("R2 aux cfg", cfg_aux, 32'h2A);
    check("R2 main kept", cfg_main, 32'h35);
  endtask

  task automatic t_rbuf;
    frame(64'hB123, 16);
    check("R3 rsel immediate", rsel, 32'h5);
    check("R3 rdiv unchanged", {rdiv_main, rdiv_aux}, 0);
  endtask

  task automatic t_areg;
    ld_m_cnt = 0; ld_a_cnt = 0;
    frame(64'h012345, 24);
    check("R1 R4 a_main msb-first", a_main, 32'h012345);
    check("R4 rdiv_main copy", rdiv_main, 32'h1123);
    check("R4 rdiv_aux untouched", rdiv_aux, 0);
    check("R4 ld_main one pulse", ld_m_cnt, 1);
    check("R4 ld_aux none", ld_a_cnt, 0);
    frame(64'h8ABCDE, 24);
    check("R4 a_aux", a_aux, 32'h0ABCDE);
    check("R4 rdiv_aux copy", rdiv_aux, 32'h1123);
    check("R4 ld_aux one pulse", ld_a_cnt, 1);
  endtask

  task automatic t_bad_len;
    frame(64'hFFF, 12);
    frame(64'hFFFFF, 20);
    frame(64'h7FFFFFF, 28);
    check("R5 cfg kept", {cfg_main, cfg_aux}, {18'd0, 7'h35, 7'h2A});
    check("R5 a kept", a_main, 32'h012345);
    check("R5 a_aux kept", a_aux, 32'h0ABCDE);
    check("R5 rsel kept", rsel, 32'h5);
  endtask

  task automatic t_long;
    frame(64'hFFFF93C456, 40);
    check("R6 last 24 bits to aux", a_aux, 32'h13C456);
    check("R6 main kept", a_main, 32'h012345);
  endtask

  task automatic t_sdo;
    logic [31:0] d = 32'hC3A50F96;
    sen_n = 1'b0; tick(4);
    for (int k = 1; k <= 32; k++) begin
      bit_out(d[32-k]);
      if (k >= 24) check("R10 sdo delayed", sdo, d[32-(k-23)]);
    end
    sen_n = 1'b1; tick(6);
    check("R10 sdo idle low", sdo, 0);
    check("R6 32-clock frame", a_aux, 32'h250F96);
  endtask

  task automatic t_mid;
    sen_n = 1'b0; tick(4);
    for (int i = 7; i >= 0; i--) bit_out(8'h77 >> i);
    tick(6);
    check("R7 no write mid-frame", cfg_main, 32'h35);
    sen_n = 1'b1; tick(6);
    check("R7 write at enable rise", cfg_main, 32'h77);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    frame(64'h12, 8);
    check("R8 idle clocks ignored", cfg_main, 32'h12);
  endtask

  task automatic t_desync;
    sclk = 1'b1; tick(4);
    sen_n = 1'b0; tick(4);
    sclk = 1'b0; tick(4);
    for (int i = 7; i >= 0; i--) bit_out(8'h05 >> i);
    sen_n = 1'b1; tick(6);
    check("R9 out-of-step frame dropped", cfg_main, 32'h12);
    frame(64'h06, 8);
    check("R9 resync frame taken", cfg_main, 32'h06);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_cfg();
    t_rbuf();
    t_areg();
    t_bad_len();
    t_long();
    t_sdo();
    t_mid();
    t_idle();
    t_desync();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule